// File: doc/BRIEF.md
# Vector Element Register Sequencer

This block expands one vector operation into a stream of per-element operations. At a start pulse it captures an element-width code, a vector length expressed in registers, a requested element count, a predicate mask and three operand descriptors: a destination and two sources. Each descriptor is a base register number and a flag that marks it as vector or scalar. While busy it emits one active element per cycle. Each element carries its index and, for each operand, a register number and a bit offset inside that 32-bit register.

Elements are packed as sub-word lanes. Lane 0 sits at bit 0, the next lane sits above it, and once a register is full the stream moves to the next register number. A scalar operand names the same whole register for every element. An element is issued only if its predicate bit is set and its index is below the effective length. Inactive elements cost no cycles. If a vector operand would address a register beyond 31, the sequence stops and an error flag is raised.

Top module: `velem_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `elem_valid` are all low.
- R2: The element-width code sets the lane count per 32-bit register. Code 3'b001 gives 8-bit lanes (4 per register). Code 3'b010 gives 16-bit lanes (2 per register). Every other code gives 32-bit lanes (1 per register).
- R3: For a vector operand with base register B, element e with L lanes of width W maps to register B + e/L at bit offset (e mod L)*W.
- R4: For a scalar operand, every element reports register B and bit offset 0.
- R5: An element e is issued only when `pred[e]` is 1 and e is below the effective length. Issued elements appear in ascending index order, each exactly once.
- R6: The effective length is the smaller of `req_len` and `vreg_len` × L.
- R7: One element is issued per busy cycle. Inactive elements cost no cycles, so a run with N issued elements keeps `busy` high for exactly N+1 cycles.
- R8: `busy` rises in the cycle after `start` is sampled high while idle, and the first element appears in that same cycle. The final busy cycle issues nothing. In the cycle after it, `busy` is low and `done` is high for exactly one cycle.
- R9: While `busy` is high, `start` and every configuration input are ignored. The running sequence is unchanged and no second run follows.
- R10: When the next active element would place any vector operand above register 31, that element and all later ones are not issued. The run ends with `err` high in the `done` cycle. `err` stays high until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| ew_code | input | 3 | Element-width code |
| vreg_len | input | VREGS_W | Vector length in registers |
| req_len | input | EIDX_W | Requested element count |
| pred | input | MAX_ELEMS | Predicate mask, bit e enables element e |
| rd_base | input | 5 | Destination base register |
| rd_vec | input | 1 | Destination is a vector operand |
| rs1_base | input | 5 | First source base register |
| rs1_vec | input | 1 | First source is a vector operand |
| rs2_base | input | 5 | Second source base register |
| rs2_vec | input | 1 | Second source is a vector operand |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run stopped on register overflow |
| elem_valid | output | 1 | An element is issued this cycle |
| elem_idx | output | EIDX_W | Index of the issued element |
| rd_reg | output | 5 | Destination register for this element |
| rd_off | output | 5 | Destination bit offset |
| rs1_reg | output | 5 | First source register |
| rs1_off | output | 5 | First source bit offset |
| rs2_reg | output | 5 | Second source register |
| rs2_off | output | 5 | Second source bit offset |

## Verification
The bench uses the default `VREGS_W` of 4. This allows up to 15 registers per vector and a 60-bit predicate with a 6-bit element index. With these values, a requested length can exceed the 8-bit-lane capacity and be clamped, and predicate bits above the clamp can be set to show they are ignored. Bases of 30 and 31 reach the register-31 overflow stop in both 32-bit and 16-bit modes. A scalar operand held at register 31 shows that scalars never trip the overflow check.

// File: rtl/velem_pkg.sv
package velem_pkg;
  localparam int REG_W    = 32;
  localparam int RIDX_W   = 5;
  localparam int NUM_REGS = 32;
  localparam int OFF_W    = 5;
  localparam int N_OPND   = 3;

  localparam logic [2:0] EWC_8  = 3'b001;
  localparam logic [2:0] EWC_16 = 3'b010;

  typedef struct packed {
    logic [RIDX_W-1:0] base;
    logic              vec;
  } opnd_t;

  // log2 of lanes per register for a width code
  function automatic logic [1:0] lane_shift(input logic [2:0] code);
    case (code)
      EWC_8:   return 2'd2;
      EWC_16:  return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // lane number times lane width (REG_W >> lsh)
  function automatic logic [OFF_W-1:0] lane_offset(input logic [1:0] lsh,
                                                   input logic [1:0] lane);
    case (lsh)
      2'd2:    return {lane, 3'b000};
      2'd1:    return {lane[0], 4'b0000};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/velem_width_dec.sv
module velem_width_dec
  import velem_pkg::*;
#(
  parameter int VREGS_W = 4,
  parameter int EIDX_W  = 6
) (
  input  logic [2:0]         ew_code,
  input  logic [VREGS_W-1:0] vreg_len,
  input  logic [EIDX_W-1:0]  req_len,
  output logic [1:0]         lsh,
  output logic [EIDX_W-1:0]  eff_len
);
  logic [EIDX_W-1:0] max_len;

  always_comb begin
    lsh     = lane_shift(ew_code);
    max_len = EIDX_W'(vreg_len) << lsh;
    eff_len = (req_len < max_len) ? req_len : max_len;
  end
endmodule

// File: rtl/velem_pick.sv
module velem_pick #(
  parameter int N  = 60,
  parameter int IW = 6
) (
  input  logic [N-1:0]  act,
  input  logic [IW-1:0] from_idx,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i] && (IW'(i) >= from_idx)) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/velem_opnd_addr.sv
module velem_opnd_addr
  import velem_pkg::*;
#(
  parameter int EIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  opnd_t             cfg,
  input  logic [1:0]        lsh,
  input  logic [EIDX_W-1:0] idx,
  output logic [RIDX_W-1:0] reg_idx,
  output logic [OFF_W-1:0]  bit_off,
  output logic              ovf
);
  localparam int SUM_W = (EIDX_W > RIDX_W) ? EIDX_W + 1 : RIDX_W + 1;

  logic [SUM_W-1:0] full;
  logic [1:0]       lane;

  always_comb begin
    lane = idx[1:0] & ~(2'b11 << lsh);
    full = SUM_W'(cfg.base) + SUM_W'(idx >> lsh);
    if (cfg.vec) begin
      reg_idx = full[RIDX_W-1:0];
      bit_off = lane_offset(lsh, lane);
      ovf     = (full > SUM_W'(NUM_REGS - 1));
    end else begin
      reg_idx = cfg.base;
      bit_off = '0;
      ovf     = 1'b0;
    end
  end

  AST_SCALAR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !cfg.vec) |-> (reg_idx == cfg.base && bit_off == '0)); // R4
  AST_VEC_NOT_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cfg.vec) |-> (reg_idx >= cfg.base)); // R3
endmodule

// File: rtl/velem_sequencer.sv
module velem_sequencer
  import velem_pkg::*;
#(
  parameter int VREGS_W = 4,
  localparam int MAX_ELEMS = ((1 << VREGS_W) - 1) * 4,
  localparam int EIDX_W    = $clog2(MAX_ELEMS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0]           ew_code,
  input  logic [VREGS_W-1:0]   vreg_len,
  input  logic [EIDX_W-1:0]    req_len,
  input  logic [MAX_ELEMS-1:0] pred,
  input  logic [RIDX_W-1:0]    rd_base,
  input  logic                 rd_vec,
  input  logic [RIDX_W-1:0]    rs1_base,
  input  logic                 rs1_vec,
  input  logic [RIDX_W-1:0]    rs2_base,
  input  logic                 rs2_vec,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic                 elem_valid,
  output logic [EIDX_W-1:0]    elem_idx,
  output logic [RIDX_W-1:0]    rd_reg,
  output logic [OFF_W-1:0]     rd_off,
  output logic [RIDX_W-1:0]    rs1_reg,
  output logic [OFF_W-1:0]     rs1_off,
  output logic [RIDX_W-1:0]    rs2_reg,
  output logic [OFF_W-1:0]     rs2_off
);
  // captured run state
  logic                 busy_q, done_q, err_q;
  logic [EIDX_W-1:0]    cur_q;
  logic [1:0]           lsh_q;
  logic [EIDX_W-1:0]    eff_len_q;
  logic [MAX_ELEMS-1:0] pred_q;
  opnd_t                ops_q [N_OPND];
  opnd_t                ops_in[N_OPND];

  // named internal events
  logic                 accept;
  logic                 finish;
  logic                 pick_found;
  logic [EIDX_W-1:0]    pick_idx;
  logic                 issue_ovf;
  logic [MAX_ELEMS-1:0] len_mask;
  logic [MAX_ELEMS-1:0] act_mask;
  logic [1:0]           lsh_d;
  logic [EIDX_W-1:0]    eff_len_d;
  logic [RIDX_W-1:0]    o_reg[N_OPND];
  logic [OFF_W-1:0]     o_off[N_OPND];
  logic [N_OPND-1:0]    o_ovf;

  assign ops_in[0] = '{base: rd_base,  vec: rd_vec};
  assign ops_in[1] = '{base: rs1_base, vec: rs1_vec};
  assign ops_in[2] = '{base: rs2_base, vec: rs2_vec};

  velem_width_dec #(.VREGS_W(VREGS_W), .EIDX_W(EIDX_W)) u_dec (
    .ew_code (ew_code),
    .vreg_len(vreg_len),
    .req_len (req_len),
    .lsh     (lsh_d),
    .eff_len (eff_len_d)
  );

  for (genvar g = 0; g < MAX_ELEMS; g++) begin : g_len
    assign len_mask[g] = (EIDX_W'(g) < eff_len_q);
  end
  assign act_mask = pred_q & len_mask;

  velem_pick #(.N(MAX_ELEMS), .IW(EIDX_W)) u_pick (
    .act     (act_mask),
    .from_idx(cur_q),
    .found   (pick_found),
    .idx     (pick_idx)
  );

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    velem_opnd_addr #(.EIDX_W(EIDX_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .issue  (elem_valid),
      .cfg    (ops_q[g]),
      .lsh    (lsh_q),
      .idx    (pick_idx),
      .reg_idx(o_reg[g]),
      .bit_off(o_off[g]),
      .ovf    (o_ovf[g])
    );
  end

  assign issue_ovf  = pick_found && (|o_ovf);
  assign elem_valid = busy_q && pick_found && !issue_ovf;
  assign finish     = busy_q && (!pick_found || issue_ovf);
  assign accept     = !busy_q && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      cur_q     <= '0;
      lsh_q     <= '0;
      eff_len_q <= '0;
      pred_q    <= '0;
      for (int i = 0; i < N_OPND; i++) ops_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        err_q     <= 1'b0;
        cur_q     <= '0;
        lsh_q     <= lsh_d;
        eff_len_q <= eff_len_d;
        pred_q    <= pred;
        for (int i = 0; i < N_OPND; i++) ops_q[i] <= ops_in[i];
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= issue_ovf;
      end else if (elem_valid) begin
        cur_q <= pick_idx + EIDX_W'(1);
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign elem_idx = pick_idx;
  assign rd_reg   = o_reg[0];
  assign rd_off   = o_off[0];
  assign rs1_reg  = o_reg[1];
  assign rs1_off  = o_off[1];
  assign rs2_reg  = o_reg[2];
  assign rs2_off  = o_off[2];

  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> busy_q); // R8
  AST_IDX_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> (elem_idx < eff_len_q)); // R6
  AST_IDX_PRED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> pred_q[elem_idx]); // R5
  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && $past(elem_valid)) |-> (elem_idx > $past(elem_idx))); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done); // R10
  AST_NO_ISSUE_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> (o_ovf == '0)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(eff_len_q) && $stable(pred_q))); // R9
endmodule

// File: tb/tb_velem_sequencer.sv
`timescale 1ns/1ps
module tb_velem_sequencer;
  localparam int VREGS_W = 4;
  localparam int MAXE    = 60;
  localparam int EW      = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] ew_code = '0;
  logic [VREGS_W-1:0] vreg_len = '0;
  logic [EW-1:0] req_len = '0;
  logic [MAXE-1:0] pred = '0;
  logic [4:0] rd_base = '0, rs1_base = '0, rs2_base = '0;
  logic rd_vec = 1'b0, rs1_vec = 1'b0, rs2_vec = 1'b0;
  logic busy, done, err, elem_valid;
  logic [EW-1:0] elem_idx;
  logic [4:0] rd_reg, rd_off, rs1_reg, rs1_off, rs2_reg, rs2_off;

  always #2.5 clk = ~clk;

  velem_sequencer #(.VREGS_W(VREGS_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ew_code(ew_code),
    .vreg_len(vreg_len), .req_len(req_len), .pred(pred),
    .rd_base(rd_base), .rd_vec(rd_vec), .rs1_base(rs1_base), .rs1_vec(rs1_vec),
    .rs2_base(rs2_base), .rs2_vec(rs2_vec), .busy(busy), .done(done), .err(err),
    .elem_valid(elem_valid), .elem_idx(elem_idx), .rd_reg(rd_reg), .rd_off(rd_off),
    .rs1_reg(rs1_reg), .rs1_off(rs1_off), .rs2_reg(rs2_reg), .rs2_off(rs2_off)
  );

  int checks = 0;
  int fails  = 0;

  int ex_n;
  bit ex_err;
  int ex_idx[64];
  int ex_reg[64][3];
  int ex_off[64][3];

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  // independent model of the expected element stream
  task automatic model(input int code, input int vlen, input int rlen,
                       input logic [MAXE-1:0] pm, input int b[3], input bit v[3]);
    int lanes, wid, eff, rr;
    bit stop;
    lanes = (code == 1) ? 4 : (code == 2) ? 2 : 1;
    wid = 32 / lanes;
    eff = vlen * lanes;
    if (rlen < eff) eff = rlen;
    ex_n = 0;
    ex_err = 1'b0;
    stop = 1'b0;
    for (int e = 0; e < eff; e++) begin
      if (pm[e] && !stop) begin
        for (int k = 0; k < 3; k++) begin
          rr = v[k] ? b[k] + e / lanes : b[k];
          if (v[k] && rr > 31) stop = 1'b1;
        end
        if (stop) ex_err = 1'b1;
        else begin
          ex_idx[ex_n] = e;
          for (int k = 0; k < 3; k++) begin
            ex_reg[ex_n][k] = v[k] ? b[k] + e / lanes : b[k];
            ex_off[ex_n][k] = v[k] ? (e % lanes) * wid : 0;
          end
          ex_n++;
        end
      end
    end
  endtask

  // one run: drive, then compare every issued element and the handshake
  task automatic run(input string req, input int code, input int vlen, input int rlen,
                     input logic [MAXE-1:0] pm, input int b[3], input bit v[3],
                     input int poke);
    int got, bcnt, cyc;
    int a_reg[3], a_off[3];
    model(code, vlen, rlen, pm, b, v);
    @(negedge clk);
    ew_code = 3'(code); vreg_len = VREGS_W'(vlen); req_len = EW'(rlen); pred = pm;
    rd_base = 5'(b[0]); rs1_base = 5'(b[1]); rs2_base = 5'(b[2]);
    rd_vec = v[0]; rs1_vec = v[1]; rs2_vec = v[2];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8", $sformatf("%s busy after start act=%b exp=1", req, busy));
    got = 0; bcnt = 0; cyc = 0;
    while (done !== 1'b1 && cyc < 200) begin
      if (busy === 1'b1) bcnt++;
      if (elem_valid === 1'b1) begin
        a_reg = '{int'(rd_reg), int'(rs1_reg), int'(rs2_reg)};
        a_off = '{int'(rd_off), int'(rs1_off), int'(rs2_off)};
        if (got < ex_n)
          chk(int'(elem_idx) == ex_idx[got] && a_reg == ex_reg[got] && a_off == ex_off[got],
              req, $sformatf("%s elem%0d act idx=%0d regs=%0d,%0d,%0d offs=%0d,%0d,%0d exp idx=%0d regs=%0d,%0d,%0d offs=%0d,%0d,%0d",
              req, got, elem_idx, a_reg[0], a_reg[1], a_reg[2], a_off[0], a_off[1], a_off[2],
              ex_idx[got], ex_reg[got][0], ex_reg[got][1], ex_reg[got][2],
              ex_off[got][0], ex_off[got][1], ex_off[got][2]));
        got++;
      end
      if (cyc == poke) begin
        start = 1'b1; pred = '1; rd_base = 5'd0; ew_code = 3'd1; req_len = EW'(1);
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(got == ex_n, "R5", $sformatf("%s count act=%0d exp=%0d", req, got, ex_n));
    chk(bcnt == ex_n + 1, "R7", $sformatf("%s busy cycles act=%0d exp=%0d", req, bcnt, ex_n + 1));
    chk(done === 1'b1 && busy === 1'b0, "R8",
        $sformatf("%s done/busy act=%b/%b exp=1/0", req, done, busy));
    chk(err === ex_err, "R10", $sformatf("%s err act=%b exp=%b", req, err, ex_err));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9",
        $sformatf("%s after done act done=%b busy=%b exp 0/0", req, done, busy));
  endtask

  task automatic t_reset();
    chk(busy === 0 && done === 0 && err === 0 && elem_valid === 0, "R1",
        $sformatf("reset act busy=%b done=%b err=%b valid=%b exp 0", busy, done, err, elem_valid));
  endtask

  task automatic t_half_words();   // R3 16-bit packing, R4 scalar rs2
    run("R3", 2, 3, 5, '1, '{2, 2, 7}, '{1'b1, 1'b1, 1'b0}, -1);
  endtask

  task automatic t_bytes_clamp();  // R2 8-bit lanes, R6 clamp, R7 skipping
    run("R6", 1, 2, 20, 60'h2A5, '{10, 4, 20}, '{1'b1, 1'b1, 1'b1}, -1);
  endtask

  task automatic t_words();        // R2 32-bit and unused code
    run("R2", 0, 3, 3, 60'h5, '{5, 9, 0}, '{1'b1, 1'b0, 1'b1}, -1);
    run("R2", 7, 2, 8, '1, '{1, 3, 6}, '{1'b1, 1'b1, 1'b0}, -1);
  endtask

  task automatic t_overflow();     // R10
    run("R10", 0, 4, 4, '1, '{30, 31, 1}, '{1'b1, 1'b0, 1'b1}, -1);
    run("R10", 2, 2, 4, '1, '{0, 31, 3}, '{1'b0, 1'b1, 1'b1}, -1);
  endtask

  task automatic t_empty();        // R5 nothing active, R10 err cleared
    run("R5", 2, 3, 6, '0, '{1, 1, 1}, '{1'b1, 1'b1, 1'b1}, -1);
    run("R6", 1, 4, 0, '1, '{1, 1, 1}, '{1'b1, 1'b1, 1'b1}, -1);
  endtask

  task automatic t_start_busy();   // R9
    run("R9", 2, 3, 5, 60'h1B, '{2, 12, 7}, '{1'b1, 1'b1, 1'b0}, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_half_words();
    t_bytes_clamp();
    t_words();
    t_overflow();
    t_empty();
    t_start_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule